// File: doc/BRIEF.md
# Two-Input Memory Request Tree Node with Starvation Bound

This block is one stage of a demand-driven tree that merges memory requests from many requestors into one stream toward a memory controller. Two child links (left and right) feed it, each through a small local buffer with valid/ready flow control. A single parent link carries requests up the tree and is driven only while the parent signals space. When both children have work, the left child wins. A blocking counter limits how long the right child can be held off: after a configurable number of left forwards have passed a waiting right request, the next forward goes to the right.

Each forwarded request gains one extra tag bit at the top of its tag. It marks the child the request came from (0 = left, 1 = right). Responses come back from memory in request order. The node reads that top bit to choose the child link, strips it, and hands the rest of the tag and the payload down. Nodes stack into a tree because each level adds one bit and removes it again on the way back.

The arbiter is a three-state machine. CLEAR means no left forward has overtaken a waiting right request. COUNTING means between 1 and M-1 have. FORCE_LOW means M have, and the right is owed the next slot. The transitions are as follows. CLEAR→COUNTING happens on a left forward while the right buffer is non-empty, or CLEAR→FORCE_LOW when M is 1. COUNTING→COUNTING happens on such a forward while the count stays below M. COUNTING→FORCE_LOW happens when that forward brings the count to M. Any state goes to CLEAR on a right forward. While the parent stalls a presented request, the chosen side is held.

Top module: `tree_mux_node`

## Requirements
- R1: After reset the parent link shows no request, both child links are ready, and no response is presented to either child.
- R2: Each child buffer holds exactly BUF_DEPTH (default 2) requests. With the parent stalled, a child link accepts two requests and then drops its ready.
- R3: A request leaves only on a cycle where out_valid and out_ready are both high. While out_valid is high and out_ready is low, the presented tag and data do not change, even if the other child gains a request.
- R4: When both buffers hold requests and fewer than BLOCK_M left forwards have passed the waiting right request, the left request is presented.
- R5: A right request that is buffered waits behind at most BLOCK_M (default 3) left forwards. With a continuous left stream, the order is three lefts and then one right.
- R6: The count restarts at zero after each right forward. Left forwards made while the right buffer is empty are not counted, so a right request arriving into a long left stream still waits for BLOCK_M lefts.
- R7: Work conservation: when the left buffer is empty and the right buffer is not, the right request is presented on the first cycle it is buffered.
- R8: out_tag is {side, child tag}, with side at bit TAG_W (0 = left, 1 = right). The child tag and data pass unchanged.
- R9: A response whose tag bit TAG_W is 0 goes to the left child and one with 1 goes to the right child. The child sees only the lower TAG_W tag bits, and rsp_ready follows the selected child's ready.
- R10: Requests from one child leave in the order that child sent them, with none lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| l_valid | input | 1 | Left child request valid |
| l_ready | output | 1 | Left buffer can accept |
| l_tag | input | TAG_W | Left child routing tag |
| l_data | input | DATA_W | Left child request payload |
| r_valid | input | 1 | Right child request valid |
| r_ready | output | 1 | Right buffer can accept |
| r_tag | input | TAG_W | Right child routing tag |
| r_data | input | DATA_W | Right child request payload |
| out_valid | output | 1 | Request presented to parent |
| out_ready | input | 1 | Parent has buffer space |
| out_tag | output | TAG_W+1 | Side bit over child tag |
| out_data | output | DATA_W | Forwarded payload |
| rsp_valid | input | 1 | Response from parent valid |
| rsp_ready | output | 1 | Response accepted by selected child |
| rsp_tag | input | TAG_W+1 | Response tag with side bit on top |
| rsp_data | input | RSP_W | Response payload |
| rl_valid | output | 1 | Response to left child valid |
| rl_ready | input | 1 | Left child takes response |
| rl_tag | output | TAG_W | Stripped tag toward left child |
| rl_data | output | RSP_W | Response payload toward left child |
| rr_valid | output | 1 | Response to right child valid |
| rr_ready | input | 1 | Right child takes response |
| rr_tag | output | TAG_W | Stripped tag toward right child |
| rr_data | output | RSP_W | Response payload toward right child |

## Verification
The bench runs a full left stream against two queued right requests and compares the exact output order against a table. A node without a blocking counter would starve the right side, and one with an off-by-one count would let the right side through after two or four lefts. It injects a right request into a long left-only stream: a counter that kept counting while the right buffer was empty would let that request through at once instead of after three lefts. The bench also stalls the parent while a right request is shown and then adds a left request, which catches an arbiter that re-decides under backpressure and changes the presented data. It checks that a lone right request goes out in its first buffered cycle, that the buffers hold exactly two, and that responses are steered by the top tag bit.

// File: rtl/node_pkg.sv
package node_pkg;

    typedef enum logic [1:0] {
        ARB_CLEAR     = 2'd0,
        ARB_COUNTING  = 2'd1,
        ARB_FORCE_LOW = 2'd2
    } arb_state_e;

    typedef enum logic {
        SIDE_LEFT  = 1'b0,
        SIDE_RIGHT = 1'b1
    } side_e;

endpackage

// File: rtl/req_buffer.sv
module req_buffer #(
    parameter int WIDTH = 10,
    parameter int DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [WIDTH-1:0] in_entry,
    output logic             out_valid,
    input  logic             out_pop,
    output logic [WIDTH-1:0] out_entry
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] store_q [DEPTH];
    logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
    logic [CNT_W-1:0] fill_q;
    logic             push, pop;

    assign out_valid = (fill_q != '0);
    assign pop       = out_pop && out_valid;
    assign in_ready  = (fill_q < CNT_W'(DEPTH)) || pop;
    assign push      = in_valid && in_ready;
    assign out_entry = store_q[rd_ptr_q];

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            fill_q   <= '0;
        end else begin
            if (push) wr_ptr_q <= ptr_next(wr_ptr_q);
            if (pop)  rd_ptr_q <= ptr_next(rd_ptr_q);
            unique case ({push, pop})
                2'b10:   fill_q <= fill_q + 1'b1;
                2'b01:   fill_q <= fill_q - 1'b1;
                default: fill_q <= fill_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push) store_q[wr_ptr_q] <= in_entry;
    end

endmodule

// File: rtl/node_arbiter.sv
module node_arbiter
    import node_pkg::*;
#(
    parameter int BLOCK_M = 3
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  hi_valid,
    input  logic  lo_valid,
    input  logic  up_ready,
    output logic  take_hi,
    output logic  take_lo,
    output logic  fwd_valid,
    output side_e fwd_side
);
    localparam int CNT_W = $clog2(BLOCK_M + 1);

    arb_state_e       state_q, state_n;
    logic [CNT_W-1:0] blk_q, blk_n;
    logic             hold_q;
    side_e            hold_side_q;

    // Output process: side selection and pop strobes.
    always_comb begin
        fwd_valid = hi_valid || lo_valid;
        if (hold_q) begin
            fwd_side = hold_side_q;
        end else if (state_q == ARB_FORCE_LOW && lo_valid) begin
            fwd_side = SIDE_RIGHT;
        end else if (hi_valid) begin
            fwd_side = SIDE_LEFT;
        end else begin
            fwd_side = SIDE_RIGHT;
        end
        take_hi = fwd_valid && up_ready && (fwd_side == SIDE_LEFT);
        take_lo = fwd_valid && up_ready && (fwd_side == SIDE_RIGHT);
    end

    // Next-state process.
    always_comb begin
        state_n = state_q;
        blk_n   = blk_q;
        unique case (state_q)
            ARB_CLEAR: begin
                if (take_hi && lo_valid) begin
                    blk_n   = CNT_W'(1);
                    state_n = (BLOCK_M == 1) ? ARB_FORCE_LOW : ARB_COUNTING;
                end
            end
            ARB_COUNTING: begin
                if (take_lo) begin
                    blk_n   = '0;
                    state_n = ARB_CLEAR;
                end else if (take_hi) begin
                    blk_n   = blk_q + 1'b1;
                    state_n = (blk_q == CNT_W'(BLOCK_M - 1)) ? ARB_FORCE_LOW
                                                             : ARB_COUNTING;
                end
            end
            ARB_FORCE_LOW: begin
                if (take_lo) begin
                    blk_n   = '0;
                    state_n = ARB_CLEAR;
                end
            end
            default: begin
                blk_n   = '0;
                state_n = ARB_CLEAR;
            end
        endcase
    end

    // State register process.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ARB_CLEAR;
            blk_q       <= '0;
            hold_q      <= 1'b0;
            hold_side_q <= SIDE_LEFT;
        end else begin
            state_q     <= state_n;
            blk_q       <= blk_n;
            hold_q      <= fwd_valid && !up_ready;
            hold_side_q <= fwd_side;
        end
    end

endmodule

// File: rtl/rsp_router.sv
module rsp_router #(
    parameter int TAG_W = 2,
    parameter int RSP_W = 8
) (
    input  logic             rsp_valid,
    output logic             rsp_ready,
    input  logic [TAG_W:0]   rsp_tag,
    input  logic [RSP_W-1:0] rsp_data,
    output logic             rl_valid,
    input  logic             rl_ready,
    output logic [TAG_W-1:0] rl_tag,
    output logic [RSP_W-1:0] rl_data,
    output logic             rr_valid,
    input  logic             rr_ready,
    output logic [TAG_W-1:0] rr_tag,
    output logic [RSP_W-1:0] rr_data
);
    logic to_right;

    always_comb begin
        to_right  = rsp_tag[TAG_W];
        rl_valid  = rsp_valid && !to_right;
        rr_valid  = rsp_valid && to_right;
        rl_tag    = rsp_tag[TAG_W-1:0];
        rr_tag    = rsp_tag[TAG_W-1:0];
        rl_data   = rsp_data;
        rr_data   = rsp_data;
        rsp_ready = to_right ? rr_ready : rl_ready;
    end

endmodule

// File: rtl/tree_mux_node.sv
module tree_mux_node
    import node_pkg::*;
#(
    parameter int TAG_W     = 2,
    parameter int DATA_W    = 8,
    parameter int RSP_W     = 8,
    parameter int BUF_DEPTH = 2,
    parameter int BLOCK_M   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_valid,
    output logic              l_ready,
    input  logic [TAG_W-1:0]  l_tag,
    input  logic [DATA_W-1:0] l_data,
    input  logic              r_valid,
    output logic              r_ready,
    input  logic [TAG_W-1:0]  r_tag,
    input  logic [DATA_W-1:0] r_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [TAG_W:0]    out_tag,
    output logic [DATA_W-1:0] out_data,
    input  logic              rsp_valid,
    output logic              rsp_ready,
    input  logic [TAG_W:0]    rsp_tag,
    input  logic [RSP_W-1:0]  rsp_data,
    output logic              rl_valid,
    input  logic              rl_ready,
    output logic [TAG_W-1:0]  rl_tag,
    output logic [RSP_W-1:0]  rl_data,
    output logic              rr_valid,
    input  logic              rr_ready,
    output logic [TAG_W-1:0]  rr_tag,
    output logic [RSP_W-1:0]  rr_data
);
    localparam int ENT_W = TAG_W + DATA_W;

    logic [1:0]       in_v, in_r, head_v, pop;
    logic [ENT_W-1:0] in_e   [2];
    logic [ENT_W-1:0] head_e [2];
    logic [ENT_W-1:0] sel_e;
    side_e            sel_side;

    assign in_v    = {r_valid, l_valid};
    assign in_e[0] = {l_tag, l_data};
    assign in_e[1] = {r_tag, r_data};
    assign l_ready = in_r[0];
    assign r_ready = in_r[1];

    for (genvar s = 0; s < 2; s++) begin : g_side
        req_buffer #(
            .WIDTH (ENT_W),
            .DEPTH (BUF_DEPTH)
        ) u_buf (
            .clk       (clk),
            .rst_n     (rst_n),
            .in_valid  (in_v[s]),
            .in_ready  (in_r[s]),
            .in_entry  (in_e[s]),
            .out_valid (head_v[s]),
            .out_pop   (pop[s]),
            .out_entry (head_e[s])
        );
    end

    node_arbiter #(
        .BLOCK_M (BLOCK_M)
    ) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .hi_valid  (head_v[0]),
        .lo_valid  (head_v[1]),
        .up_ready  (out_ready),
        .take_hi   (pop[0]),
        .take_lo   (pop[1]),
        .fwd_valid (out_valid),
        .fwd_side  (sel_side)
    );

    assign sel_e    = (sel_side == SIDE_RIGHT) ? head_e[1] : head_e[0];
    assign out_tag  = {sel_side == SIDE_RIGHT, sel_e[ENT_W-1:DATA_W]};
    assign out_data = sel_e[DATA_W-1:0];

    rsp_router #(
        .TAG_W (TAG_W),
        .RSP_W (RSP_W)
    ) u_rsp (
        .rsp_valid (rsp_valid),
        .rsp_ready (rsp_ready),
        .rsp_tag   (rsp_tag),
        .rsp_data  (rsp_data),
        .rl_valid  (rl_valid),
        .rl_ready  (rl_ready),
        .rl_tag    (rl_tag),
        .rl_data   (rl_data),
        .rr_valid  (rr_valid),
        .rr_ready  (rr_ready),
        .rr_tag    (rr_tag),
        .rr_data   (rr_data)
    );

endmodule

// File: rtl/node_checker.sv
module node_checker #(
    parameter int TAG_W     = 2,
    parameter int DATA_W    = 8,
    parameter int BUF_DEPTH = 2,
    parameter int BLOCK_M   = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              l_valid,
    input logic              l_ready,
    input logic              r_valid,
    input logic              r_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [TAG_W:0]    out_tag,
    input logic [DATA_W-1:0] out_data,
    input logic              rsp_valid,
    input logic              rsp_side,
    input logic              rl_valid,
    input logic              rr_valid
);
    localparam int OCC_W = $clog2(BUF_DEPTH + 2);
    localparam int BLK_W = $clog2(BLOCK_M + 2);

    logic [OCC_W-1:0] occ_l, occ_r;
    logic [BLK_W-1:0] blk;
    logic             stall_q;
    logic             fire, fire_l, fire_r;

    assign fire   = out_valid && out_ready;
    assign fire_l = fire && !out_tag[TAG_W];
    assign fire_r = fire && out_tag[TAG_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            occ_l   <= '0;
            occ_r   <= '0;
            blk     <= '0;
            stall_q <= 1'b0;
        end else begin
            occ_l   <= occ_l + OCC_W'(l_valid && l_ready) - OCC_W'(fire_l);
            occ_r   <= occ_r + OCC_W'(r_valid && r_ready) - OCC_W'(fire_r);
            stall_q <= out_valid && !out_ready;
            if (fire_r || occ_r == '0) blk <= '0;
            else if (fire_l)           blk <= blk + 1'b1;
        end
    end

    // R2
    buf_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (occ_l <= OCC_W'(BUF_DEPTH)) && (occ_r <= OCC_W'(BUF_DEPTH)));

    // R3
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_tag) && $stable(out_data)));

    // R4
    left_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall_q && occ_l != '0 && occ_r != '0 && blk < BLK_W'(BLOCK_M))
            |-> (out_valid && !out_tag[TAG_W]));

    // R5
    starve_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_l && occ_r != '0) |-> (blk < BLK_W'(BLOCK_M)));

    // R7
    work_cons_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (occ_l == '0 && occ_r != '0) |-> (out_valid && out_tag[TAG_W]));

    // R9
    rsp_steer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ((rl_valid != rr_valid) && (rr_valid == rsp_side)));

endmodule

bind tree_mux_node node_checker #(
    .TAG_W     (TAG_W),
    .DATA_W    (DATA_W),
    .BUF_DEPTH (BUF_DEPTH),
    .BLOCK_M   (BLOCK_M)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .l_valid   (l_valid),
    .l_ready   (l_ready),
    .r_valid   (r_valid),
    .r_ready   (r_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_tag   (out_tag),
    .out_data  (out_data),
    .rsp_valid (rsp_valid),
    .rsp_side  (rsp_tag[TAG_W]),
    .rl_valid  (rl_valid),
    .rr_valid  (rr_valid)
);

// File: tb/test_tree_mux_node.sv
module test_tree_mux_node;
    localparam int TAG_W = 2;
    localparam int DW    = 8;
    localparam int RW    = 8;

    // Expected output order for a full left stream against two queued rights.
    // Payload bit 7 = source side, low bits = per-side sequence number.
    localparam logic [7:0] EXP_A [8] = '{8'h00, 8'h01, 8'h02, 8'h80,
                                         8'h03, 8'h04, 8'h05, 8'h81};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic l_valid = 1'b0, r_valid = 1'b0, out_ready = 1'b0;
    logic l_ready, r_ready, out_valid, rsp_ready, rl_valid, rr_valid;
    logic [TAG_W-1:0] l_tag = '0, r_tag = '0, rl_tag, rr_tag;
    logic [DW-1:0] l_data = '0, r_data = '0, out_data;
    logic [TAG_W:0] out_tag, rsp_tag = '0;
    logic rsp_valid = 1'b0, rl_ready = 1'b0, rr_ready = 1'b0;
    logic [RW-1:0] rsp_data = '0, rl_data, rr_data;

    int checks = 0, fails = 0, cyc = 0;
    int l_left = 0, r_left = 0, l_seq = 0, r_seq = 0;
    bit l_hs = 0, r_hs = 0;
    logic [7:0] log_d [64];
    logic [2:0] log_t [64];
    int n_log = 0;
    bit watch_arm = 0, watch_on = 0, watch_done = 0;
    int watch_cnt = 0;

    always #5 clk = ~clk;

    tree_mux_node i_tree_mux_node (
        .clk(clk), .rst_n(rst_n),
        .l_valid(l_valid), .l_ready(l_ready), .l_tag(l_tag), .l_data(l_data),
        .r_valid(r_valid), .r_ready(r_ready), .r_tag(r_tag), .r_data(r_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_tag(out_tag), .out_data(out_data),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_tag(rsp_tag), .rsp_data(rsp_data),
        .rl_valid(rl_valid), .rl_ready(rl_ready), .rl_tag(rl_tag), .rl_data(rl_data),
        .rr_valid(rr_valid), .rr_ready(rr_ready), .rr_tag(rr_tag), .rr_data(rr_data)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Monitor at the falling edge: log parent fires and time a right arrival.
    always @(negedge clk) begin
        l_hs = l_valid && l_ready;
        r_hs = r_valid && r_ready;
        if (out_valid && out_ready) begin
            if (n_log < 64) begin
                log_d[n_log] = out_data;
                log_t[n_log] = out_tag;
                n_log++;
            end
            if (watch_on) begin
                if (out_tag[TAG_W]) begin
                    watch_on = 0;
                    watch_done = 1;
                end else begin
                    watch_cnt++;
                end
            end
        end
        if (r_hs && watch_arm) begin
            watch_arm = 0;
            watch_on = 1;
            watch_cnt = 0;
        end
    end

    // Child feeders: each keeps valid high while it has requests left.
    always @(posedge clk) begin
        #1;
        if (l_hs) begin l_seq++; l_left--; end
        if (r_hs) begin r_seq++; r_left--; end
        l_valid = (l_left > 0);
        l_data  = {1'b0, l_seq[6:0]};
        l_tag   = l_seq[1:0];
        r_valid = (r_left > 0);
        r_data  = {1'b1, r_seq[6:0]};
        r_tag   = r_seq[1:0];
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 20000);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic drain();
        out_ready = 1'b1;
        repeat (25) @(posedge clk);
        #2;
    endtask

    initial begin
        logic [7:0] hold_d;
        int nl;
        bit ord_ok;
        repeat (3) @(posedge clk);
        #2;
        // R1: reset state
        @(negedge clk);
        check(!out_valid, "R1 out_valid", out_valid, 0);
        check(l_ready && r_ready, "R1 child ready", {l_ready, r_ready}, 3);
        check(!rl_valid && !rr_valid, "R1 rsp idle", {rl_valid, rr_valid}, 0);
        rst_n = 1'b1;
        @(posedge clk); #2;

        // R4 R5 R6 R8 R10: full left stream versus two queued rights
        out_ready = 1'b0;
        l_left = 6;
        r_left = 2;
        repeat (5) @(posedge clk);
        #2;
        n_log = 0;
        out_ready = 1'b1;
        repeat (14) @(posedge clk);
        #2;
        check(n_log == 8, "R10 count", n_log, 8);
        for (int i = 0; i < 8; i++) begin
            check(log_d[i] == EXP_A[i] && log_t[i] == {EXP_A[i][7], EXP_A[i][1:0]},
                  "R5 order/R8 tag", {log_t[i], log_d[i]},
                  {EXP_A[i][7], EXP_A[i][1:0], EXP_A[i]});
        end
        drain();

        // R7: lone right request goes out on its first buffered cycle
        r_left = 1;
        wait (r_hs);
        @(negedge clk);
        check(out_valid && out_tag[TAG_W], "R7 work conserving",
              {out_valid, out_tag[TAG_W]}, 3);
        drain();

        // R3: stalled right stays presented when a left arrives
        out_ready = 1'b0;
        r_left = 1;
        repeat (3) @(negedge clk);
        check(out_valid && out_tag[TAG_W], "R3 right shown", {out_valid, out_tag}, 4);
        hold_d = out_data;
        l_left = 1;
        repeat (3) @(negedge clk);
        check(out_tag[TAG_W] && out_data == hold_d, "R3 stall stable",
              {out_tag, out_data}, {3'b100, hold_d});
        out_ready = 1'b1;
        @(negedge clk);
        check(out_valid && !out_tag[TAG_W], "R3 left after release",
              {out_valid, out_tag[TAG_W]}, 2);
        drain();

        // R6: right arriving into a long left-only stream waits for three lefts
        l_left = 14;
        repeat (6) @(posedge clk);
        #2;
        watch_done = 0;
        watch_arm = 1;
        r_left = 1;
        repeat (30) @(posedge clk);
        #2;
        check(watch_done && watch_cnt == 3, "R6 count restart", watch_cnt, 3);
        drain();

        // R2: two-entry buffer under parent stall
        out_ready = 1'b0;
        begin
            int s0;
            s0 = l_seq;
            l_left = 5;
            repeat (8) @(posedge clk);
            #2;
            check(l_seq - s0 == 2, "R2 buffer depth", l_seq - s0, 2);
            check(!l_ready, "R2 ready low when full", l_ready, 0);
            n_log = 0;
            out_ready = 1'b1;
            repeat (20) @(posedge clk);
            #2;
            nl = 0;
            ord_ok = 1;
            for (int i = 0; i < n_log; i++) begin
                if (!log_t[i][TAG_W]) begin
                    if (log_d[i] != 8'(s0 + nl)) ord_ok = 0;
                    nl++;
                end
            end
            check(nl == 5, "R10 none lost", nl, 5);
            check(ord_ok, "R10 in order", ord_ok, 1);
        end

        // R9: response steering by tag bit TAG_W
        @(posedge clk); #2;
        rsp_valid = 1'b1;
        rsp_tag = 3'b010;
        rsp_data = 8'hA5;
        rl_ready = 1'b1;
        rr_ready = 1'b0;
        #1;
        check(rl_valid && !rr_valid && rl_tag == 2'b10 && rl_data == 8'hA5,
              "R9 to left", {rl_valid, rr_valid, rl_tag, rl_data}, {4'b1010, 8'hA5});
        check(rsp_ready, "R9 left ready", rsp_ready, 1);
        rsp_tag = 3'b101;
        rsp_data = 8'h3C;
        #1;
        check(rr_valid && !rl_valid && rr_tag == 2'b01 && rr_data == 8'h3C,
              "R9 to right", {rr_valid, rl_valid, rr_tag, rr_data}, {4'b1001, 8'h3C});
        check(!rsp_ready, "R9 right ready", rsp_ready, 0);
        @(posedge clk); #2;
        rsp_valid = 1'b0;

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule